// File: doc/BRIEF.md
# Semaphore-Gated Message Channel

This block moves messages from a producer tile to a consumer tile, with at most one message in flight between them. The producer streams a message into a buffer in its own tile. When the message is complete, the producer unblocks a semaphore at the consumer and reports the message length with it. The consumer polls that flag locally and clears it as it begins to pull the words back over the network. It reads every word, then sends a completion notice. The completion notice is the only thing that lets the producer start the next message.

Both halves of the pair sit in one module. The network links between them are exposed as four valid/ready channels: the unblock, the read request, the read response and the completion notice. The surrounding fabric can stall any of these links on any cycle. The consumer's processor receives the pulled words on a simple output stream.

Top module: `sem_msg_channel`

## Requirements
- R1: `send_ready` goes low in the cycle after the final word of a message is accepted. It stays low until the cycle after the producer-side completion handshake (`p_done_valid && p_done_ready`). No word is taken while a message is outstanding.
- R2: Message words are stored in the producer buffer at addresses 0, 1, 2 and so on, in the order they are accepted. A buffer write changes nothing on the consumer side until the consumer reads that word.
- R3: After the final word, `p_sem_valid` rises with `p_sem_len` equal to the word count. Both stay stable until `p_sem_ready` is seen.
- R4: `c_sem_ready` is high only while the consumer is idle and its local flag is clear. The flag is cleared when reading starts, so one unblock starts exactly one read sequence.
- R5: For a length L, the consumer issues exactly L read requests, with `c_rreq_addr` going 0 to L-1 in order. Each request is held stable until it is accepted.
- R6: For each accepted read request, the producer returns exactly one response carrying the buffer word at that address, in request order. The response is held stable under backpressure.
- R7: Each accepted response appears on `rx_data` with `rx_valid` in the same cycle. `rx_last` marks the L-th word.
- R8: After the last response, the consumer raises `c_done_valid` and holds it until it is accepted. Each message produces exactly one completion.
- R9: After reset, `send_ready` is 1 and every valid output is 0.
- R10: A message that fills all DEPTH buffer words without `send_last` ends on its DEPTH-th word, with length DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_valid | input | 1 | Producer word valid |
| send_ready | output | 1 | Producer word accepted |
| send_data | input | DW | Producer word |
| send_last | input | 1 | Final word of message |
| p_sem_valid | output | 1 | Unblock to network |
| p_sem_ready | input | 1 | Network accepts unblock |
| p_sem_len | output | LW | Message length |
| p_rreq_valid | input | 1 | Read request from network |
| p_rreq_ready | output | 1 | Read request accepted |
| p_rreq_addr | input | AW | Buffer word address |
| p_rrsp_valid | output | 1 | Read response to network |
| p_rrsp_ready | input | 1 | Network accepts response |
| p_rrsp_data | output | DW | Read data |
| p_done_valid | input | 1 | Completion from network |
| p_done_ready | output | 1 | Completion accepted |
| c_sem_valid | input | 1 | Unblock arriving at consumer |
| c_sem_ready | output | 1 | Consumer flag free |
| c_sem_len | input | LW | Arriving length |
| c_rreq_valid | output | 1 | Consumer read request |
| c_rreq_ready | input | 1 | Network accepts request |
| c_rreq_addr | output | AW | Requested address |
| c_rrsp_valid | input | 1 | Response at consumer |
| c_rrsp_ready | output | 1 | Consumer takes response |
| c_rrsp_data | input | DW | Response data |
| c_done_valid | output | 1 | Completion to network |
| c_done_ready | input | 1 | Network accepts completion |
| rx_valid | output | 1 | Received word valid |
| rx_data | output | DW | Received word |
| rx_last | output | 1 | Final received word |

## Verification
The completion notice can arrive at the producer in the same cycle that the next message's first word is waiting on `send_valid`. The bench keeps `send_valid` high straight after each final word, so every release meets a waiting send. In every cycle it checks that `send_ready` is still low during the handshake cycle itself and rises only one cycle later. It also checks that the first word of the new message never shows up among the received words of the old one. The network links are stalled at random on all four channels, so these collisions occur at many different points in the read sequence.

// File: rtl/sem_msg_channel.sv
module sem_msg_channel #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          send_valid,
  output logic          send_ready,
  input  logic [DW-1:0] send_data,
  input  logic          send_last,
  output logic          p_sem_valid,
  input  logic          p_sem_ready,
  output logic [LW-1:0] p_sem_len,
  input  logic          p_rreq_valid,
  output logic          p_rreq_ready,
  input  logic [AW-1:0] p_rreq_addr,
  output logic          p_rrsp_valid,
  input  logic          p_rrsp_ready,
  output logic [DW-1:0] p_rrsp_data,
  input  logic          p_done_valid,
  output logic          p_done_ready,
  input  logic          c_sem_valid,
  output logic          c_sem_ready,
  input  logic [LW-1:0] c_sem_len,
  output logic          c_rreq_valid,
  input  logic          c_rreq_ready,
  output logic [AW-1:0] c_rreq_addr,
  input  logic          c_rrsp_valid,
  output logic          c_rrsp_ready,
  input  logic [DW-1:0] c_rrsp_data,
  output logic          c_done_valid,
  input  logic          c_done_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_last
);

  typedef enum logic [1:0] {P_FILL, P_SEM, P_PEND} pst_t;
  typedef enum logic [1:0] {C_IDLE, C_READ, C_DONE} cst_t;

  pst_t          pst;
  logic [DW-1:0] store [DEPTH];
  logic [LW-1:0] wcnt;
  logic [LW-1:0] len_q;
  logic          rsp_full;
  logic [DW-1:0] rsp_q;

  wire w_go  = send_valid && send_ready;
  wire w_end = w_go && (send_last || wcnt == LW'(DEPTH - 1));
  wire rq_go = p_rreq_valid && p_rreq_ready;

  assign send_ready   = (pst == P_FILL);
  assign p_sem_valid  = (pst == P_SEM);
  assign p_sem_len    = len_q;
  assign p_done_ready = (pst == P_PEND);
  assign p_rreq_ready = !rsp_full || p_rrsp_ready;
  assign p_rrsp_valid = rsp_full;
  assign p_rrsp_data  = rsp_q;

  always_ff @(posedge clk) begin
    if (w_go) store[wcnt[AW-1:0]] <= send_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst   <= P_FILL;
      wcnt  <= '0;
      len_q <= '0;
    end else begin
      case (pst)
        P_FILL: if (w_go) begin
          wcnt <= wcnt + 1'b1;
          if (w_end) begin
            len_q <= wcnt + 1'b1;
            wcnt  <= '0;
            pst   <= P_SEM;
          end
        end
        P_SEM:  if (p_sem_ready) pst <= P_PEND;
        P_PEND: if (p_done_valid) pst <= P_FILL;
        default: pst <= P_FILL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_full <= 1'b0;
      rsp_q    <= '0;
    end else if (rq_go) begin
      rsp_full <= 1'b1;
      rsp_q    <= store[p_rreq_addr];
    end else if (p_rrsp_ready) begin
      rsp_full <= 1'b0;
    end
  end

  cst_t          cst;
  logic          flag;
  logic [LW-1:0] c_len;
  logic [LW-1:0] iss;
  logic [LW-1:0] got;

  wire last_rsp = (got == c_len - 1'b1);

  assign c_sem_ready  = !flag && (cst == C_IDLE);
  assign c_rreq_valid = (cst == C_READ) && (iss < c_len);
  assign c_rreq_addr  = iss[AW-1:0];
  assign c_rrsp_ready = (cst == C_READ);
  assign c_done_valid = (cst == C_DONE);
  assign rx_valid     = c_rrsp_valid && c_rrsp_ready;
  assign rx_data      = c_rrsp_data;
  assign rx_last      = rx_valid && last_rsp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst   <= C_IDLE;
      flag  <= 1'b0;
      c_len <= '0;
      iss   <= '0;
      got   <= '0;
    end else begin
      if (c_sem_valid && c_sem_ready) begin
        flag  <= 1'b1;
        c_len <= c_sem_len;
      end
      case (cst)
        C_IDLE: if (flag) begin
          flag <= 1'b0;
          iss  <= '0;
          got  <= '0;
          cst  <= C_READ;
        end
        C_READ: begin
          if (c_rreq_valid && c_rreq_ready) iss <= iss + 1'b1;
          if (rx_valid) begin
            got <= got + 1'b1;
            if (last_rsp) cst <= C_DONE;
          end
        end
        C_DONE: if (c_done_ready) cst <= C_IDLE;
        default: cst <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sem_msg_channel_chk.sv
module sem_msg_channel_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          send_valid,
  input logic          send_ready,
  input logic          send_last,
  input logic          p_sem_valid,
  input logic          p_sem_ready,
  input logic [LW-1:0] p_sem_len,
  input logic          p_rrsp_valid,
  input logic          p_rrsp_ready,
  input logic [DW-1:0] p_rrsp_data,
  input logic          p_done_valid,
  input logic          p_done_ready,
  input logic          c_rreq_valid,
  input logic          c_rreq_ready,
  input logic [AW-1:0] c_rreq_addr,
  input logic          c_done_valid,
  input logic          c_done_ready
);

  logic [1:0] out_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) out_cnt <= '0;
    else out_cnt <= out_cnt + 2'((p_sem_valid && p_sem_ready) ? 1 : 0)
                            - 2'((p_done_valid && p_done_ready) ? 1 : 0);
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= 2'd1); // R1
  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    send_ready |-> out_cnt == 2'd0); // R1
  AST_LAST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (send_valid && send_ready && send_last) |=> !send_ready); // R1
  AST_SEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (p_sem_valid && !p_sem_ready) |=> p_sem_valid && $stable(p_sem_len)); // R3
  AST_RREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rreq_valid && !c_rreq_ready) |=> c_rreq_valid && $stable(c_rreq_addr)); // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rrsp_valid && !p_rrsp_ready) |=> p_rrsp_valid && $stable(p_rrsp_data)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_done_valid && !c_done_ready) |=> c_done_valid); // R8

endmodule

bind sem_msg_channel sem_msg_channel_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_sem_msg_channel.sv
module sim_sem_msg_channel;
  localparam int DW = 16, DEPTH = 8;
  localparam int AW = $clog2(DEPTH), LW = $clog2(DEPTH + 1);
  localparam int NMSG = 11;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic send_valid = 0, send_last = 0, send_ready;
  logic [DW-1:0] send_data = '0;
  logic p_sem_valid, p_sem_ready, p_rreq_valid, p_rreq_ready, p_rrsp_valid, p_rrsp_ready;
  logic p_done_valid, p_done_ready, c_sem_valid, c_sem_ready, c_rreq_valid, c_rreq_ready;
  logic c_rrsp_valid, c_rrsp_ready, c_done_valid, c_done_ready, rx_valid, rx_last;
  logic [LW-1:0] p_sem_len, c_sem_len;
  logic [AW-1:0] p_rreq_addr, c_rreq_addr;
  logic [DW-1:0] p_rrsp_data, c_rrsp_data, rx_data;
  logic g_sem = 0, g_rq = 0, g_rs = 0, g_dn = 0;

  assign c_sem_valid  = p_sem_valid & g_sem;
  assign p_sem_ready  = c_sem_ready & g_sem;
  assign c_sem_len    = p_sem_len;
  assign p_rreq_valid = c_rreq_valid & g_rq;
  assign c_rreq_ready = p_rreq_ready & g_rq;
  assign p_rreq_addr  = c_rreq_addr;
  assign c_rrsp_valid = p_rrsp_valid & g_rs;
  assign p_rrsp_ready = c_rrsp_ready & g_rs;
  assign c_rrsp_data  = p_rrsp_data;
  assign p_done_valid = c_done_valid & g_dn;
  assign c_done_ready = p_done_ready & g_dn;

  sem_msg_channel #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  always @(posedge clk) begin
    #1;
    g_sem <= ($urandom % 10) < 6;
    g_rq  <= ($urandom % 10) < 7;
    g_rs  <= ($urandom % 10) < 6;
    g_dn  <= ($urandom % 10) < 5;
  end

  int n_chk = 0, n_fail = 0, n_done = 0;
  logic [DW:0] exp_q[$];
  int len_q[$];
  logic drv_end = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_msg(int n, bit use_last);
    len_q.push_back(n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      send_valid = 1;
      send_data  = DW'($urandom);
      send_last  = use_last && (i == n - 1);
      drv_end    = (i == n - 1);
      @(negedge clk);
      while (!send_ready) @(negedge clk);
      exp_q.push_back({drv_end, send_data});
    end
  endtask

  bit pend = 0, cbusy = 0;
  int raddr = 0;
  always @(negedge clk) if (rst_n) begin
    chk(send_ready == !pend, "R1 send_ready vs outstanding", send_ready, !pend);
    chk(c_sem_ready == !cbusy, "R4 consumer flag ready", c_sem_ready, !cbusy);
    if (p_sem_valid && p_sem_ready) begin
      int e;
      e = (len_q.size() > 0) ? len_q.pop_front() : -1;
      chk(int'(p_sem_len) == e, "R3 R10 unblock length", p_sem_len, e);
    end
    if (c_sem_valid && c_sem_ready) begin cbusy = 1; raddr = 0; end
    if (c_rreq_valid && c_rreq_ready) begin
      chk(int'(c_rreq_addr) == raddr, "R5 read address order", c_rreq_addr, raddr);
      raddr++;
    end
    if (rx_valid) begin
      logic [DW:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
      chk(rx_data == e[DW-1:0], "R2 R6 R7 received data", rx_data, e[DW-1:0]);
      chk(rx_last == e[DW], "R7 R10 last marker", rx_last, e[DW]);
    end
    if (c_done_valid && c_done_ready) begin
      cbusy = 0;
      n_done++;
    end
    if (p_done_valid && p_done_ready) pend = 0;
    if (send_valid && send_ready && drv_end) pend = 1;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(send_ready == 1, "R9 reset send_ready", send_ready, 1);
    chk({p_sem_valid, p_rrsp_valid, c_rreq_valid, c_done_valid, rx_valid} == 0,
        "R9 reset valids", {p_sem_valid, p_rrsp_valid, c_rreq_valid, c_done_valid, rx_valid}, 0);
    send_msg(1, 1);
    send_msg(3, 1);
    send_msg(DEPTH, 0);
    send_msg(2, 1);
    send_msg(5, 1);
    for (int m = 0; m < NMSG - 5; m++) send_msg(1 + ($urandom % DEPTH), 1);
    @(posedge clk); #1 send_valid = 0; drv_end = 0;
    while (n_done < NMSG) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(n_done == NMSG, "R8 completions", n_done, NMSG);
    chk(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", n_done, NMSG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule